// File: doc/BRIEF.md
# Configuration Request Packet Builder

This block sits on the host side of a PCIe root port. It takes one configuration-space access at a time and turns it into a request packet. Each access names a target bus, a device/function byte, a register offset, a size of one, two or four bytes, a read/write flag and write data. The block first screens the access. It refuses devices that cannot exist behind a single-slot root port, targets beyond a link that is down, and the root port's own first base address register. An access that passes the screen becomes a three-doubleword header, plus data for a write. The block sends it as 64-bit beats with start and end markers over a valid/ready stream.

The block keeps its own copy of the root bus number. This copy decides between the local (Type 0) and forwarded (Type 1) request formats, and it supplies the bus half of the requester ID. Software renumbers the root port by writing the primary bus register, and the block follows that write. Each access ends in a one-cycle response pulse that reports whether the packet went out or why it was refused.

Top module: `cfg_req_packer`

## Requirements
- R1: Beat 1 bits 31:0 carry header word 0, with the format/type byte in bits 31:24 and the value 0x000001 in bits 23:0. The byte is 0x04 for a read and 0x44 for a write when the target bus equals the tracked root bus. It is 0x05 for a read and 0x45 for a write on any other bus.
- R2: Beat 1 bits 63:32 carry header word 1. It holds the requester ID {root bus, devfn} in bits 31:16, a tag of 0x1D for reads or 0x10 for writes in bits 15:8, zero in bits 7:4, and the byte enables in bits 3:0.
- R3: Size code 0 is one byte, with enables 0001 shifted left by offset[1:0]. Code 1 is two bytes, with enables 0011 shifted by offset[1:0] and truncated to four bits. Codes 2 and 3 are four bytes, with enables 1111. For one- and two-byte writes the data is masked to its size and shifted left by 8 times offset[1:0]; four-byte data is sent unchanged.
- R4: Header word 2 holds the target bus in bits 31:24 and devfn in bits 23:16. Bits 15:0 hold the offset with bits 1:0 cleared.
- R5: A read, or a write whose dword-aligned offset has bit 2 set, goes out as two beats. Beat 1 carries the start marker. Beat 2 carries the end marker, header word 2 in bits 31:0 and the shifted write data in bits 63:32 (zero for reads).
- R6: A write whose offset has bits 2:0 clear goes out as three beats. Beat 2 carries header word 2 in bits 31:0, zero above, and no marker. Beat 3 carries the data in bits 31:0, zero above, and the end marker.
- R7: An access is refused with status 1 (not found), read data 0xFFFFFFFF and no beats in three cases: device number devfn[7:3] non-zero on the root bus; device number non-zero on bus root+1; any non-root bus while link_up is low.
- R8: An access to bus = root bus, devfn 0x00 and dword-aligned offset 0x10 is refused with status 2 (bad register), read data zero and no beats.
- R9: The tracked root bus resets to 0. A write to the root bus at dword-aligned offset 0x18 loads the low byte of its shifted data into the root bus. The load takes effect on the edge where the last beat is handed off, and root_bus changes at no other time.
- R10: An access is taken only when req_valid is high and busy is low. Busy and tx_valid rise on the edge after a taken access and fall on the edge after the end beat is handed off. While tx_ready is low, the beat and its markers hold steady. Requests presented while busy have no effect.
- R11: rsp_valid pulses for one cycle. For a refusal it comes in the cycle after the access is taken. For a sent packet it comes in the cycle after the end beat is handed off, with status 0 and read data zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Device (7:3) and function (2:0) |
| req_offset | input | OFF_W | Register byte offset |
| req_size | input | 2 | 0 = byte, 1 = half word, 2/3 = word |
| req_wdata | input | 32 | Write data, right-justified |
| link_up | input | 1 | Link is in the active state |
| busy | output | 1 | A packet is being sent |
| tx_valid | output | 1 | Beat valid |
| tx_ready | input | 1 | Downstream accepts the beat |
| tx_data | output | 64 | Beat payload |
| tx_sop | output | 1 | First beat of a packet |
| tx_eop | output | 1 | Last beat of a packet |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 2 | 0 sent, 1 not found, 2 bad register |
| rsp_rdata | output | 32 | All ones on not found, else zero |
| root_bus | output | 8 | Tracked root bus number |

## Verification
The assertions assume that tx_ready is a plain input sampled at the clock and that no request is in flight while reset is low. The stability property takes no view on when the sink asserts ready. The bench changes every input on the falling edge and raises req_valid for one cycle at a time. It deliberately presents one request while busy, to show it is ignored. It holds tx_ready low over a stretch of cycles to exercise the hold property, and it keeps tx_ready high elsewhere so that beat counts are exact.

// File: rtl/cfgpkt_pkg.sv
package cfgpkt_pkg;
  localparam int BUS_W  = 8;
  localparam int DW_W   = 32;
  localparam int BEAT_W = 64;
  localparam logic [7:0] TAG_RD = 8'h1D;
  localparam logic [7:0] TAG_WR = 8'h10;

  typedef enum logic [1:0] {
    CS_SENT      = 2'd0,
    CS_NOT_FOUND = 2'd1,
    CS_BAD_REG   = 2'd2
  } cfg_status_e;

  // byte-enable nibble from size code and low offset bits
  function automatic logic [3:0] lane_enables(input logic [1:0] size,
                                              input logic [1:0] lo);
    logic [3:0] base;
    case (size)
      2'd0:    base = 4'b0001 << lo;
      2'd1:    base = 4'b0011 << lo;
      default: base = 4'b1111;
    endcase
    return base;
  endfunction

  // place write data on its byte lanes
  function automatic logic [31:0] lane_align(input logic [31:0] d,
                                             input logic [1:0] size,
                                             input logic [1:0] lo);
    logic [31:0] r;
    case (size)
      2'd0:    r = {24'd0, d[7:0]}  << (8 * lo);
      2'd1:    r = {16'd0, d[15:0]} << (8 * lo);
      default: r = d;
    endcase
    return r;
  endfunction

  // format/type byte: bit6 = write, bit2 = config, bit0 = forwarded
  function automatic logic [7:0] fmt_code(input logic wr, input logic fwd);
    return {1'b0, wr, 3'b000, 1'b1, 1'b0, fwd};
  endfunction
endpackage

// File: rtl/cfgpkt_filter.sv
module cfgpkt_filter
  import cfgpkt_pkg::*;
#(
  parameter int OFF_W      = 12,
  parameter int BAR_OFFSET = 'h10
) (
  input  logic [7:0]       root_bus,
  input  logic [7:0]       bus,
  input  logic [7:0]       devfn,
  input  logic [OFF_W-1:0] off_dw,
  input  logic             link_up,
  output logic             is_local,
  output cfg_status_e      verdict
);
  logic below_root;
  logic dev_nonzero;
  logic bar_hit;

  always_comb begin
    is_local    = (bus == root_bus);
    below_root  = (bus == 8'(root_bus + 8'd1));
    dev_nonzero = (devfn[7:3] != 5'd0);
    bar_hit     = is_local && (devfn == 8'd0) && (off_dw == OFF_W'(BAR_OFFSET));
    if (bar_hit)
      verdict = CS_BAD_REG;
    else if (is_local && dev_nonzero)
      verdict = CS_NOT_FOUND;
    else if (below_root && dev_nonzero)
      verdict = CS_NOT_FOUND;
    else if (!is_local && !link_up)
      verdict = CS_NOT_FOUND;
    else
      verdict = CS_SENT;
  end
endmodule

// File: rtl/cfgpkt_hdr.sv
module cfgpkt_hdr
  import cfgpkt_pkg::*;
#(
  parameter int OFF_W = 12
) (
  input  logic [7:0]       root_bus,
  input  logic             is_local,
  input  logic             write,
  input  logic [7:0]       bus,
  input  logic [7:0]       devfn,
  input  logic [OFF_W-1:0] offset,
  input  logic [1:0]       size,
  input  logic [31:0]      wdata,
  output logic [31:0]      hw0,
  output logic [31:0]      hw1,
  output logic [31:0]      hw2,
  output logic [31:0]      payload,
  output logic             three_beat
);
  logic [15:0] off16;
  logic [3:0]  be;

  always_comb begin
    off16 = '0;
    off16[OFF_W-1:0] = offset;
    off16[1:0] = 2'b00;
    be      = lane_enables(size, offset[1:0]);
    hw0     = {fmt_code(write, !is_local), 24'd1};
    hw1     = {root_bus, devfn, (write ? TAG_WR : TAG_RD), 4'd0, be};
    hw2     = {bus, devfn, off16};
    payload = write ? lane_align(wdata, size, offset[1:0]) : 32'd0;
    three_beat = write && (offset[2] == 1'b0);
  end
endmodule

// File: rtl/cfgpkt_seq.sv
module cfgpkt_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] hw0,
  input  logic [31:0] hw1,
  input  logic [31:0] hw2,
  input  logic [31:0] payload,
  input  logic        three_beat,
  input  logic        tx_ready,
  output logic        busy,
  output logic        tx_valid,
  output logic [63:0] tx_data,
  output logic        tx_sop,
  output logic        tx_eop,
  output logic        last_handoff
);
  logic [31:0] w0_q, w1_q, w2_q, pl_q;
  logic        three_q;
  logic [1:0]  idx_q;
  logic        busy_q;
  logic        handoff;

  always_comb begin
    tx_valid = busy_q;
    busy     = busy_q;
    tx_sop   = (idx_q == 2'd0);
    tx_eop   = three_q ? (idx_q == 2'd2) : (idx_q == 2'd1);
    case (idx_q)
      2'd0:    tx_data = {w1_q, w0_q};
      2'd1:    tx_data = three_q ? {32'd0, w2_q} : {pl_q, w2_q};
      default: tx_data = {32'd0, pl_q};
    endcase
    handoff      = busy_q && tx_ready;
    last_handoff = handoff && tx_eop;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= 2'd0;
      three_q <= 1'b0;
      w0_q    <= '0;
      w1_q    <= '0;
      w2_q    <= '0;
      pl_q    <= '0;
    end else if (load) begin
      busy_q  <= 1'b1;
      idx_q   <= 2'd0;
      three_q <= three_beat;
      w0_q    <= hw0;
      w1_q    <= hw1;
      w2_q    <= hw2;
      pl_q    <= payload;
    end else if (last_handoff) begin
      busy_q <= 1'b0;
      idx_q  <= 2'd0;
    end else if (handoff) begin
      idx_q <= idx_q + 2'd1;
    end
  end
endmodule

// File: rtl/cfg_req_packer.sv
module cfg_req_packer
  import cfgpkt_pkg::*;
#(
  parameter int OFF_W         = 12,
  parameter int BAR_OFFSET    = 'h10,
  parameter int BUSNUM_OFFSET = 'h18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [7:0]       req_bus,
  input  logic [7:0]       req_devfn,
  input  logic [OFF_W-1:0] req_offset,
  input  logic [1:0]       req_size,
  input  logic [31:0]      req_wdata,
  input  logic             link_up,
  output logic             busy,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [63:0]      tx_data,
  output logic             tx_sop,
  output logic             tx_eop,
  output logic             rsp_valid,
  output logic [1:0]       rsp_status,
  output logic [31:0]      rsp_rdata,
  output logic [7:0]       root_bus
);
  logic [OFF_W-1:0] off_dw;
  logic             is_local;
  cfg_status_e      verdict;
  logic [31:0]      hw0, hw1, hw2, payload;
  logic             three_beat;
  logic             accept, take, refuse, beat_done;
  logic             renum_hit;
  logic             renum_pend_q;
  logic [7:0]       renum_val_q;
  logic [7:0]       root_q;

  always_comb begin
    off_dw = req_offset;
    off_dw[1:0] = 2'b00;
    accept    = req_valid && !busy;
    take      = accept && (verdict == CS_SENT);
    refuse    = accept && (verdict != CS_SENT);
    renum_hit = req_write && is_local && (off_dw == OFF_W'(BUSNUM_OFFSET));
    root_bus  = root_q;
  end

  cfgpkt_filter #(.OFF_W(OFF_W), .BAR_OFFSET(BAR_OFFSET)) u_filter (
    .root_bus (root_q),
    .bus      (req_bus),
    .devfn    (req_devfn),
    .off_dw   (off_dw),
    .link_up  (link_up),
    .is_local (is_local),
    .verdict  (verdict)
  );

  cfgpkt_hdr #(.OFF_W(OFF_W)) u_hdr (
    .root_bus   (root_q),
    .is_local   (is_local),
    .write      (req_write),
    .bus        (req_bus),
    .devfn      (req_devfn),
    .offset     (req_offset),
    .size       (req_size),
    .wdata      (req_wdata),
    .hw0        (hw0),
    .hw1        (hw1),
    .hw2        (hw2),
    .payload    (payload),
    .three_beat (three_beat)
  );

  cfgpkt_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (take),
    .hw0          (hw0),
    .hw1          (hw1),
    .hw2          (hw2),
    .payload      (payload),
    .three_beat   (three_beat),
    .tx_ready     (tx_ready),
    .busy         (busy),
    .tx_valid     (tx_valid),
    .tx_data      (tx_data),
    .tx_sop       (tx_sop),
    .tx_eop       (tx_eop),
    .last_handoff (beat_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      root_q       <= 8'd0;
      renum_pend_q <= 1'b0;
      renum_val_q  <= 8'd0;
      rsp_valid    <= 1'b0;
      rsp_status   <= CS_SENT;
      rsp_rdata    <= 32'd0;
    end else begin
      if (take) begin
        renum_pend_q <= renum_hit;
        renum_val_q  <= payload[7:0];
      end
      if (beat_done && renum_pend_q)
        root_q <= renum_val_q;
      rsp_valid  <= refuse || beat_done;
      rsp_status <= refuse ? verdict : CS_SENT;
      rsp_rdata  <= (refuse && verdict == CS_NOT_FOUND) ? 32'hFFFF_FFFF : 32'd0;
    end
  end
endmodule

// File: rtl/cfg_req_packer_chk.sv
module cfg_req_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [63:0] tx_data,
  input logic        tx_sop,
  input logic        tx_eop,
  input logic        rsp_valid,
  input logic [1:0]  rsp_status,
  input logic [31:0] rsp_rdata,
  input logic [7:0]  root_bus,
  input logic        beat_done
);
  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop)));

  assert_idle_after_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_eop) |=> !busy);

  assert_fmt_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_sop) |-> (tx_data[31:24] inside {8'h04, 8'h44, 8'h05, 8'h45} && tx_data[23:0] == 24'd1));

  assert_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_sop) |-> (tx_data[47:40] inside {8'h1D, 8'h10}));

  assert_no_single_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_sop) |-> !tx_eop);

  assert_notfound_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'd1) |-> (rsp_rdata == 32'hFFFF_FFFF));

  assert_sent_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done |=> (rsp_valid && rsp_status == 2'd0));

  assert_root_moves_on_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(root_bus) |-> $past(beat_done));
endmodule

bind cfg_req_packer cfg_req_packer_chk u_chk (.*);

// File: tb/cfg_req_packer_test.sv
module cfg_req_packer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_bus = 8'd0, req_devfn = 8'd0;
  logic [11:0] req_offset = 12'd0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_wdata = 32'd0;
  logic        link_up = 1'b1;
  logic        busy, tx_valid, tx_sop, tx_eop, rsp_valid;
  logic        tx_ready = 1'b1;
  logic [63:0] tx_data;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_rdata;
  logic [7:0]  root_bus;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cfg_req_packer uut (.*);

  typedef struct packed {
    logic        wr;
    logic [7:0]  bus;
    logic [7:0]  devfn;
    logic [11:0] off;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic        link;
    logic [1:0]  nbeats;
    logic [1:0]  st;
    logic [63:0] e0;
    logic [63:0] e1;
    logic [63:0] e2;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{1'b0, 8'h00, 8'h00, 12'h000, 2'd2, 32'h0, 1'b1, 2'd2, 2'd0,
      64'h00001D0F_04000001, 64'h00000000_00000000, 64'h0},
    '{1'b0, 8'h03, 8'h08, 12'h02A, 2'd0, 32'h0, 1'b1, 2'd2, 2'd0,
      64'h00081D04_05000001, 64'h00000000_03080028, 64'h0},
    '{1'b1, 8'h02, 8'h00, 12'h046, 2'd1, 32'h0000BEEF, 1'b1, 2'd2, 2'd0,
      64'h0000100C_45000001, 64'hBEEF0000_02000044, 64'h0},
    '{1'b1, 8'h00, 8'h00, 12'h008, 2'd2, 32'h12345678, 1'b1, 2'd3, 2'd0,
      64'h0000100F_44000001, 64'h00000000_00000008, 64'h00000000_12345678},
    '{1'b1, 8'h05, 8'h11, 12'h101, 2'd0, 32'h000000AB, 1'b1, 2'd3, 2'd0,
      64'h00111002_45000001, 64'h00000000_05110100, 64'h00000000_0000AB00},
    '{1'b0, 8'h00, 8'h08, 12'h000, 2'd2, 32'h0, 1'b1, 2'd0, 2'd1, 64'h0, 64'h0, 64'h0},
    '{1'b0, 8'h01, 8'h10, 12'h000, 2'd2, 32'h0, 1'b1, 2'd0, 2'd1, 64'h0, 64'h0, 64'h0},
    '{1'b0, 8'h04, 8'h00, 12'h000, 2'd2, 32'h0, 1'b0, 2'd0, 2'd1, 64'h0, 64'h0, 64'h0},
    '{1'b0, 8'h00, 8'h00, 12'h010, 2'd2, 32'h0, 1'b1, 2'd0, 2'd2, 64'h0, 64'h0, 64'h0},
    '{1'b1, 8'h00, 8'h01, 12'h010, 2'd2, 32'hCAFEF00D, 1'b1, 2'd3, 2'd0,
      64'h0001100F_44000001, 64'h00000000_00010010, 64'h00000000_CAFEF00D},
    '{1'b0, 8'h00, 8'h00, 12'h013, 2'd0, 32'h0, 1'b1, 2'd0, 2'd2, 64'h0, 64'h0, 64'h0},
    '{1'b0, 8'h01, 8'h00, 12'h000, 2'd2, 32'h0, 1'b1, 2'd2, 2'd0,
      64'h00001D0F_05000001, 64'h00000000_01000000, 64'h0}
  };

  logic [63:0] got_beat [4];
  logic        got_sop [4];
  logic        got_eop [4];
  int          got_n;
  logic        got_rsp;
  logic [1:0]  got_st;
  logic [31:0] got_rd;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [7:0] bus, input logic [7:0] devfn,
                       input logic [11:0] off, input logic [1:0] sz,
                       input logic [31:0] wd, input logic lk);
    @(negedge clk);
    req_write = wr; req_bus = bus; req_devfn = devfn; req_offset = off;
    req_size = sz; req_wdata = wd; link_up = lk; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic collect();
    got_n = 0;
    while (tx_valid && got_n < 4) begin
      got_beat[got_n] = tx_data;
      got_sop[got_n]  = tx_sop;
      got_eop[got_n]  = tx_eop;
      got_n++;
      @(negedge clk);
    end
    got_rsp = rsp_valid;
    got_st  = rsp_status;
    got_rd  = rsp_rdata;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R10 watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(busy == 1'b0 && tx_valid == 1'b0, "R10 reset idle", {62'd0, busy, tx_valid}, 64'd0);
    check(rsp_valid == 1'b0, "R11 reset no response", 64'(rsp_valid), 64'd0);
    check(root_bus == 8'd0, "R9 reset root bus", 64'(root_bus), 64'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VT[i];
      issue(v.wr, v.bus, v.devfn, v.off, v.size, v.wdata, v.link);
      collect();
      check(got_n == int'(v.nbeats), $sformatf("R5/R6/R7 beat count v%0d", i),
            64'(got_n), 64'(v.nbeats));
      check(got_rsp == 1'b1, $sformatf("R11 response pulse v%0d", i), 64'(got_rsp), 64'd1);
      check(got_st == v.st, $sformatf("R7/R8 status v%0d", i), 64'(got_st), 64'(v.st));
      if (v.st == 2'd1)
        check(got_rd == 32'hFFFFFFFF, $sformatf("R7 read data v%0d", i), 64'(got_rd), 64'hFFFFFFFF);
      else
        check(got_rd == 32'd0, $sformatf("R8/R11 read data v%0d", i), 64'(got_rd), 64'd0);
      if (got_n == int'(v.nbeats) && v.nbeats != 2'd0) begin
        check(got_beat[0] == v.e0, $sformatf("R1/R2/R3 beat1 v%0d", i), got_beat[0], v.e0);
        check(got_beat[1] == v.e1, $sformatf("R4/R5/R6 beat2 v%0d", i), got_beat[1], v.e1);
        check(got_sop[0] && !got_eop[0] && !got_sop[1], $sformatf("R5 markers beat1/2 v%0d", i),
              {62'd0, got_sop[0], got_eop[0]}, 64'd2);
        if (v.nbeats == 2'd3) begin
          check(!got_eop[1], $sformatf("R6 beat2 no end v%0d", i), 64'(got_eop[1]), 64'd0);
          check(got_beat[2] == v.e2 && got_eop[2], $sformatf("R6 beat3 v%0d", i), got_beat[2], v.e2);
        end else begin
          check(got_eop[1], $sformatf("R5 beat2 end v%0d", i), 64'(got_eop[1]), 64'd1);
        end
      end
      @(negedge clk);
      check(rsp_valid == 1'b0, $sformatf("R11 single pulse v%0d", i), 64'(rsp_valid), 64'd0);
    end
    check(root_bus == 8'd0, "R9 root unchanged by other writes", 64'(root_bus), 64'd0);

    // backpressure, request while busy ignored
    issue(1'b1, 8'h00, 8'h00, 12'h000, 2'd2, 32'h01020304, 1'b1);
    tx_ready = 1'b0;
    check(busy && tx_valid, "R10 busy after accept", {62'd0, busy, tx_valid}, 64'd3);
    begin
      logic [63:0] held;
      held = tx_data;
      req_write = 1'b0; req_bus = 8'h00; req_devfn = 8'h08; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (2) @(negedge clk);
      check(tx_data == held && tx_sop, "R10 beat held while stalled", tx_data, held);
      check(rsp_valid == 1'b0, "R10 request while busy ignored", 64'(rsp_valid), 64'd0);
    end
    tx_ready = 1'b1;
    collect();
    check(got_n == 3, "R6 stalled write beat count", 64'(got_n), 64'd3);
    check(got_rsp && got_st == 2'd0, "R10 ignored request left no refusal", 64'(got_st), 64'd0);
    @(negedge clk);
    check(busy == 1'b0 && rsp_valid == 1'b0, "R10 idle after packet", {62'd0, busy, rsp_valid}, 64'd0);

    // renumber the root bus
    issue(1'b1, 8'h00, 8'h00, 12'h018, 2'd2, 32'h00000305, 1'b1);
    check(root_bus == 8'd0, "R9 no change before end beat", 64'(root_bus), 64'd0);
    collect();
    check(got_n == 3, "R6 renumber write beats", 64'(got_n), 64'd3);
    check(root_bus == 8'h05, "R9 root bus loaded", 64'(root_bus), 64'h05);

    issue(1'b0, 8'h05, 8'h00, 12'h004, 2'd2, 32'h0, 1'b0);
    collect();
    check(got_n == 2, "R1 new root read beats", 64'(got_n), 64'd2);
    check(got_beat[0] == 64'h05001D0F_04000001, "R1/R2 local type with new root",
          got_beat[0], 64'h05001D0F_04000001);
    check(got_beat[1] == 64'h00000000_05000004, "R4 header word 2 new root",
          got_beat[1], 64'h00000000_05000004);

    issue(1'b0, 8'h06, 8'h08, 12'h000, 2'd2, 32'h0, 1'b1);
    collect();
    check(got_n == 0 && got_rsp && got_st == 2'd1, "R7 below new root device 1",
          64'(got_st), 64'd1);

    issue(1'b0, 8'h00, 8'h00, 12'h000, 2'd2, 32'h0, 1'b1);
    collect();
    check(got_beat[0][31:24] == 8'h05, "R1 old root bus now forwarded",
          64'(got_beat[0][31:24]), 64'h05);

    summary();
  end
endmodule